// File: doc/BRIEF.md
# Runtime-Selectable Shift-Add Constant Multiplier

This block multiplies a 16-bit signed input by one of two fixed constants, 12305 or 20746. A one-bit select input picks the constant for each word. It contains no general multiplier. One shared graph of three adders does the work, with the shifts between them fixed in the wiring. The choice of constant is made by 2:1 multiplexers inside that graph. Some multiplexers pick one of two shift amounts for the same signal, and one picks which signal feeds an adder. Where both constants use the same shift on an adder input, that input has no multiplexer.

The first adder forms 3x when the select is 0, or 5x when it is 1. The second adder and the final adder build on that result. For select 0 they form x + 16x + 3x·4096. For select 1 they form (5x·16 + x)·256 + 5x·2. The intermediate values may be even. Because of this, the last adder already gives the full product, and no multiplexer sits at the output.

Both data ports use a valid/ready stream interface. A word is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. Its product appears in a registered output stage one cycle later. While that output is valid, it is held until the consumer raises `out_ready`. While it is held, `in_ready` stays low, so back-pressure reaches the producer in the same cycle. When `out_ready` is high, the stage passes one word per cycle.

Top module: `rcm_shiftadd_mult`

## Requirements
- R1: When a word is accepted with `in_sel` = 0, the product later presented is exactly 12305 times the signed `in_x`, as a 32-bit two's complement value.
- R2: When a word is accepted with `in_sel` = 1, the product later presented is exactly 20746 times the signed `in_x`, as a 32-bit two's complement value.
- R3: The extreme inputs 0, 1, -1, 32767 and -32768 give exact products for both select values, with no wrap-around.
- R4: After a transfer at a rising edge (`in_valid` and `in_ready` both high), `out_valid` is high and `out_prod` holds that word's product right after that same edge.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_prod` do not change. This holds even if `in_x`, `in_sel` or `in_valid` change.
- R6: `in_ready` is high exactly when the output stage is empty or `out_ready` is high. With `out_ready` held high, one word is accepted every cycle.
- R7: A synchronous active-high `rst` clears `out_valid` and `out_prod` to 0 at the next rising edge, even if a result is being held.
- R8: When `out_ready` is high and `in_valid` is low at a rising edge, `out_valid` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_x | input | 16 | Signed multiplicand, two's complement |
| in_sel | input | 1 | Constant choice: 0 selects 12305, 1 selects 20746 |
| out_valid | output | 1 | Product is present |
| out_ready | input | 1 | Consumer takes the product this cycle |
| out_prod | output | 32 | Signed product, two's complement |

## Verification
Suppose one multiplexer chooses the wrong shift amount, or the final adder takes the wrong source. The product for that select value is then wrong one cycle after acceptance. This error shows up for almost every input value, so the bench sweeps every 16-bit input under both select values. A stuck or mis-steered handshake bit in the output stage behaves differently: it drops, repeats or overwrites a held product. That is seen on the next edge, either as a changed `out_prod` during a stall or as a wrong `out_valid` after a drain. Reset errors leave stale data visible right after the reset edge.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

  // The two selectable multiplicands
  localparam int unsigned CONST_LO = 12305;  // in_sel = 0
  localparam int unsigned CONST_HI = 20746;  // in_sel = 1

  // Wired shift amounts of the shared graph, one pair per adder input:
  // first value for select 0, second for select 1.
  // first adder:  x + (x << S1)                      -> 3x | 5x
  localparam int unsigned S1_LO  = 1;
  localparam int unsigned S1_HI  = 2;
  // second adder: (t1 << S2L) + (x << S2R)           -> 12304x | 81x
  localparam int unsigned S2L_LO = 12;
  localparam int unsigned S2L_HI = 4;
  localparam int unsigned S2R_LO = 4;
  localparam int unsigned S2R_HI = 0;
  // third adder:  (t2 << S3L) + (src << S3R), src = x | t1
  localparam int unsigned S3L_LO = 0;
  localparam int unsigned S3L_HI = 8;
  localparam int unsigned S3R_LO = 0;
  localparam int unsigned S3R_HI = 1;

  typedef enum logic {
    PICK_LO = 1'b0,
    PICK_HI = 1'b1
  } cpick_e;

endpackage

// File: rtl/rcm_shift_pick.sv
// Selects between two wired left shifts of one signal. Equal shifts need no mux.
module rcm_shift_pick #(
  parameter int unsigned W   = 32,
  parameter int unsigned SH0 = 0,
  parameter int unsigned SH1 = 0
) (
  input  logic         sel,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (SH0 == SH1) begin : g_fixed
      assign dout = din << SH0;
    end else begin : g_mux
      assign dout = sel ? (din << SH1) : (din << SH0);
    end
  endgenerate

endmodule

// File: rtl/rcm_graph.sv
// Shared three-adder graph; the constant is switched by muxes on adder inputs.
module rcm_graph
  import rcm_pkg::*;
#(
  parameter int unsigned XW = 16,
  parameter int unsigned PW = 32
) (
  input  logic          sel,
  input  logic [XW-1:0] x,
  output logic [PW-1:0] prod
);

  localparam int unsigned EXT = PW - XW;

  logic [PW-1:0] xe;
  logic [PW-1:0] x_s1, t1;
  logic [PW-1:0] t1_s2, x_s2, t2;
  logic [PW-1:0] t2_s3, src3, src_s3;

  assign xe = {{EXT{x[XW-1]}}, x};

  // stage 1: 3x or 5x
  rcm_shift_pick #(.W(PW), .SH0(S1_LO), .SH1(S1_HI)) u_pick_s1 (
    .sel(sel), .din(xe), .dout(x_s1));
  assign t1 = xe + x_s1;

  // stage 2: 12304x or 81x
  rcm_shift_pick #(.W(PW), .SH0(S2L_LO), .SH1(S2L_HI)) u_pick_s2l (
    .sel(sel), .din(t1), .dout(t1_s2));
  rcm_shift_pick #(.W(PW), .SH0(S2R_LO), .SH1(S2R_HI)) u_pick_s2r (
    .sel(sel), .din(xe), .dout(x_s2));
  assign t2 = t1_s2 + x_s2;

  // stage 3: source mux on the right input, then the final sum (no output mux)
  assign src3 = (cpick_e'(sel) == PICK_HI) ? t1 : xe;
  rcm_shift_pick #(.W(PW), .SH0(S3L_LO), .SH1(S3L_HI)) u_pick_s3l (
    .sel(sel), .din(t2), .dout(t2_s3));
  rcm_shift_pick #(.W(PW), .SH0(S3R_LO), .SH1(S3R_HI)) u_pick_s3r (
    .sel(sel), .din(src3), .dout(src_s3));
  assign prod = t2_s3 + src_s3;

  always_comb begin
    if (!$isunknown({sel, x})) begin
      AST_FIRST_SUM: assert (t1 == PW'($signed(xe) * (sel ? 5 : 3)))
        else $error("first adder value wrong");  // R2
      AST_PRODUCT: assert ($signed(prod) ==
                           $signed(PW'($signed(xe) * (sel ? int'(CONST_HI) : int'(CONST_LO)))))
        else $error("graph product wrong");  // R1
    end
  end

endmodule

// File: rtl/rcm_out_stage.sv
// valid/ready output register; OUT_REG = 0 gives a combinational pass-through.
module rcm_out_stage #(
  parameter int unsigned PW      = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] d,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] q
);

  generate
    if (OUT_REG) begin : g_reg
      logic          vld_r;
      logic [PW-1:0] dat_r;

      assign in_ready  = !vld_r || out_ready;
      assign out_valid = vld_r;
      assign q         = dat_r;

      always_ff @(posedge clk) begin
        if (rst) begin
          vld_r <= 1'b0;
          dat_r <= '0;
        end else if (in_ready) begin
          vld_r <= in_valid;
          if (in_valid) dat_r <= d;
        end
      end

      AST_ACCEPT_FILL: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid && q == $past(d))
        else $error("accepted word not presented");  // R4
      AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(q))
        else $error("held product changed");  // R5
      AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready)
        else $error("ready high while stalled");  // R6
      AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        out_ready && !in_valid |=> !out_valid)
        else $error("valid stayed high after drain");  // R8
    end else begin : g_wire
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign q         = d;
    end
  endgenerate

endmodule

// File: rtl/rcm_shiftadd_mult.sv
module rcm_shiftadd_mult #(
  parameter int unsigned XW      = 16,
  parameter int unsigned PW      = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [XW-1:0] in_x,
  input  logic          in_sel,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_prod
);

  logic [PW-1:0] graph_prod;

  rcm_graph #(.XW(XW), .PW(PW)) u_graph (
    .sel  (in_sel),
    .x    (in_x),
    .prod (graph_prod)
  );

  rcm_out_stage #(.PW(PW), .OUT_REG(OUT_REG)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         (graph_prod),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (out_prod)
  );

endmodule

// File: tb/test_rcm_shiftadd_mult.sv
`timescale 1ns/1ps
module test_rcm_shiftadd_mult;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_x;
  logic        in_sel;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_prod;

  int checks = 0;
  int failures = 0;
  bit summary_done = 1'b0;

  always #2.5 clk = ~clk;

  rcm_shiftadd_mult i_rcm_shiftadd_mult (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_sel(in_sel), .out_valid(out_valid),
    .out_ready(out_ready), .out_prod(out_prod));

  function automatic longint expect_prod(logic [15:0] x, logic s);
    return longint'($signed(x)) * (s ? 64'sd20746 : 64'sd12305);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_prod(string req, logic [15:0] x, logic s);
    longint e = expect_prod(x, s);
    longint a = longint'($signed(out_prod));
    check(out_valid && a == e, req, out_valid ? a : -1, e);
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // single transfer, consumer ready, sampled after the capturing edge
  task automatic single(string req, logic [15:0] x, logic s);
    @(negedge clk);
    in_valid = 1'b1; in_x = x; in_sel = s; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_prod(req, x, s);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] px;
    logic        ps;
    bit          have_prev;
    rst = 1'b1; in_valid = 1'b0; in_x = '0; in_sel = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R7 reset state
    check(!out_valid && out_prod == 0, "R7 reset", longint'(out_prod), 0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R6 empty ready", in_ready, 1);

    // R3 corner inputs, both constants (R1 / R2 through the same path)
    for (int s = 0; s < 2; s++) begin
      single("R3 zero",   16'h0000, s[0]);
      single("R3 one",    16'h0001, s[0]);
      single("R3 minus1", 16'hFFFF, s[0]);
      single("R3 max",    16'h7FFF, s[0]);
      single("R3 min",    16'h8000, s[0]);
    end

    // R5 / R6 back-pressure
    @(negedge clk);
    in_valid = 1'b1; in_x = 16'd1234; in_sel = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check_prod("R4 latency", 16'd1234, 1'b1);
    check(in_ready == 1'b0, "R6 stalled ready", in_ready, 0);
    in_x = -16'sd77; in_sel = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check_prod("R5 hold", 16'd1234, 1'b1);
    end
    out_ready = 1'b1;
    #0.5;
    check(in_ready == 1'b1, "R6 release ready", in_ready, 1);
    @(negedge clk);
    check_prod("R5 after release", -16'sd77, 1'b0);
    in_valid = 1'b0;
    @(negedge clk);
    check(!out_valid, "R8 drain", out_valid, 0);

    // R7 reset while holding a result
    in_valid = 1'b1; in_x = 16'd999; in_sel = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check(!out_valid && out_prod == 0, "R7 mid reset", longint'(out_prod), 0);
    rst = 1'b0; out_ready = 1'b1;
    @(negedge clk);

    // R1 / R2 exhaustive sweep, one word per cycle (R4, R6)
    have_prev = 1'b0; px = '0; ps = 1'b0;
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 65536; v++) begin
        @(negedge clk);
        if (have_prev) check_prod(ps ? "R2 sweep" : "R1 sweep", px, ps);
        in_valid = 1'b1; in_x = v[15:0]; in_sel = s[0];
        px = v[15:0]; ps = s[0]; have_prev = 1'b1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    check_prod(ps ? "R2 sweep" : "R1 sweep", px, ps);
    @(negedge clk);
    check(!out_valid, "R8 final drain", out_valid, 0);

    finish_run();
  end

endmodule